// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the 32 data registers of a geometry coprocessor. A host writes a register through a write port (enable, 5-bit index, 32-bit word), and reads one back through a combinational read port that takes an index and returns a 32-bit word. Each index has its own rule for what a read returns. Accumulators and packed words come back unchanged. Some 16-bit quantities come back sign-extended and others zero-extended. One index acts as a push port into a three-deep screen-coordinate queue. One read-only index reports the leading-sign count of its source register.

The colour conversion indices are stubs that hold nothing. Arithmetic commands are not part of this block. A write takes effect at the rising clock edge. A read reflects the stored state in the same cycle, with no extra latency.

Top module: `cop_data_regfile`

## Requirements
- R1: Indices 0, 6, 23, 24, 25 store and return all 32 bits unchanged, for example 0xDEADBEEF written to 25 reads back as 0xDEADBEEF. Indices 2–5, 17–22, 26, 27 and 30 follow the same rule.
- R2: Indices 1 and 8–11 return bit 15 of the written word copied into bits 31:16, with bits 15:0 unchanged. For example, 0x0000FF00 written to 1 reads 0xFFFFFF00, and 0x00001234 written to 10 reads 0x00001234.
- R3: Indices 7 and 16 return the low 16 bits of the written word with bits 31:16 cleared. For example, 0xDEADBEEF written to 16 reads 0x0000BEEF.
- R4: Indices 12, 13 and 14 are the queue entries (oldest, middle, newest). Each can be written directly and returns its full 32-bit word.
- R5: A write to index 15 moves entry 13 into 12 and entry 14 into 13, then places the written word in entry 14, all at one clock edge.
- R6: A read of index 15 returns the current content of entry 14.
- R7: A read of index 31 returns the number of leading bits of index 30 that equal its bit 31. The count is 32 for 0 and for 0xFFFFFFFF, 1 for 0x80000000, 31 for 0x00000001, and 15 for both 0x00010000 and 0xFFFE0000.
- R8: A write to index 31 changes no register. After it, index 31 and index 30 read as before.
- R9: Indices 28 and 29 are stubs. They always read 0 and ignore writes.
- R10: After reset, every index except 31 reads 0, and index 31 reads 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 5 | Register index to write |
| wrData | input | 32 | Write data |
| rdIdx | input | 5 | Register index to read |
| rdData | output | 32 | Read data, combinational from rdIdx and the stored state |

## Verification
The hardest state to reach from the ports is a queue where all three entries hold different values, because only then is the ordering of a push visible. The stimulus first fills entries 12 to 14 directly with distinct words, then pushes a fourth word, and checks all three entries. It then pushes three words into a queue that already holds data and checks that every older value has been flushed out. Ignored writes to index 31 are checked by reading both the count and its source register straight afterwards.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W = 5;
  localparam int HALF_W = 16;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  localparam logic [IDX_W-1:0] IDX_Q_OLD = 5'd12;
  localparam logic [IDX_W-1:0] IDX_Q_MID = 5'd13;
  localparam logic [IDX_W-1:0] IDX_Q_NEW = 5'd14;
  localparam logic [IDX_W-1:0] IDX_Q_PUSH = 5'd15;
  localparam logic [IDX_W-1:0] IDX_LSC_SRC = 5'd30;
  localparam logic [IDX_W-1:0] IDX_LSC_OUT = 5'd31;
  localparam logic [IDX_W-1:0] IDX_STUB_A = 5'd28;
  localparam logic [IDX_W-1:0] IDX_STUB_B = 5'd29;

  typedef enum logic [2:0] {
    RD_RAW, RD_SEXT, RD_ZEXT, RD_QTOP, RD_LSC, RD_ZERO
  } rdMode_e;

  typedef struct packed {
    logic store;
    logic push;
    logic [IDX_W-1:0] idx;
  } wrStrobe_t;
endpackage

// File: rtl/cop_lead_sign_count.sv
module cop_lead_sign_count #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] src,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] flipped;
  logic found;

  always_comb begin
    flipped = src ^ {WIDTH{src[WIDTH-1]}};
    count = CW'(WIDTH);
    found = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!found && flipped[i]) begin
        count = CW'(WIDTH - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cop_regs_ctrl.sv
module cop_regs_ctrl
  import cop_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output wrStrobe_t        strobe,
  output rdMode_e          rdMode
);
  logic wrBlocked;

  always_comb begin
    wrBlocked = (wrIdx == IDX_Q_PUSH) || (wrIdx == IDX_LSC_OUT) ||
                (wrIdx == IDX_STUB_A) || (wrIdx == IDX_STUB_B);
    strobe.idx = wrIdx;
    strobe.store = wrEn && !wrBlocked;
    strobe.push = wrEn && (wrIdx == IDX_Q_PUSH);
  end

  always_comb begin
    case (rdIdx)
      5'd1, 5'd8, 5'd9, 5'd10, 5'd11: rdMode = RD_SEXT;
      5'd7, 5'd16:                    rdMode = RD_ZEXT;
      IDX_Q_PUSH:                     rdMode = RD_QTOP;
      IDX_LSC_OUT:                    rdMode = RD_LSC;
      IDX_STUB_A, IDX_STUB_B:         rdMode = RD_ZERO;
      default:                        rdMode = RD_RAW;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.store, strobe.push}) <= 1); // R5
  AST_RO_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrIdx == IDX_LSC_OUT) |-> !strobe.store); // R8
endmodule

// File: rtl/cop_regs_dp.sv
module cop_regs_dp
  import cop_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  rdMode_e           rdMode,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] rawWord;
  logic [CNT_W-1:0] lscCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strobe.store) begin
      regFile[strobe.idx] <= wrData;
    end else if (strobe.push) begin
      regFile[IDX_Q_OLD] <= regFile[IDX_Q_MID];
      regFile[IDX_Q_MID] <= regFile[IDX_Q_NEW];
      regFile[IDX_Q_NEW] <= wrData;
    end
  end

  cop_lead_sign_count #(.WIDTH(DATA_W)) u_lsc (
    .src(regFile[IDX_LSC_SRC]),
    .count(lscCount)
  );

  always_comb begin
    rawWord = regFile[rdIdx];
    case (rdMode)
      RD_SEXT: rdData = {{(DATA_W-HALF_W){rawWord[HALF_W-1]}}, rawWord[HALF_W-1:0]};
      RD_ZEXT: rdData = {{(DATA_W-HALF_W){1'b0}}, rawWord[HALF_W-1:0]};
      RD_QTOP: rdData = regFile[IDX_Q_NEW];
      RD_LSC:  rdData = {{(DATA_W-CNT_W){1'b0}}, lscCount};
      RD_ZERO: rdData = '0;
      default: rdData = rawWord;
    endcase
  end

  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.push |=> (regFile[IDX_Q_NEW] == $past(wrData)) &&
                    (regFile[IDX_Q_MID] == $past(regFile[IDX_Q_NEW])) &&
                    (regFile[IDX_Q_OLD] == $past(regFile[IDX_Q_MID]))); // R5
  AST_SEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMode == RD_SEXT) |-> (rdData[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){rdData[HALF_W-1]}})); // R2
  AST_ZEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMode == RD_ZEXT) |-> (rdData[DATA_W-1:HALF_W] == '0)); // R3
  AST_LSC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMode == RD_LSC) |-> (rdData >= 1 && rdData <= DATA_W)); // R7
  AST_STUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMode == RD_ZERO) |-> (rdData == '0)); // R9
  AST_QTOP_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMode == RD_QTOP) |-> (rdData == regFile[IDX_Q_NEW])); // R6
endmodule

// File: rtl/cop_data_regfile.sv
module cop_data_regfile
  import cop_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  wrStrobe_t strobe;
  rdMode_e rdMode;

  cop_regs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .strobe(strobe), .rdMode(rdMode)
  );

  cop_regs_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .rdIdx(rdIdx), .rdMode(rdMode), .rdData(rdData)
  );
endmodule

// File: tb/cop_data_regfile_bench.sv
module cop_data_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [4:0] rdIdx = '0;
  logic [31:0] rdData;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cop_data_regfile u_cop_data_regfile (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData)
  );

  // {write index, write data, read index, expected, requirement number}
  localparam int NVEC = 19;
  localparam logic [77:0] VECS [NVEC] = '{
    {5'd24, 32'h12345678, 5'd24, 32'h12345678, 4'd1},  // R1
    {5'd25, 32'hdeadbeef, 5'd25, 32'hdeadbeef, 4'd1},  // R1
    {5'd0,  32'h00640032, 5'd0,  32'h00640032, 4'd1},  // R1
    {5'd6,  32'haa554080, 5'd6,  32'haa554080, 4'd1},  // R1
    {5'd23, 32'hdeadbeef, 5'd23, 32'hdeadbeef, 4'd1},  // R1
    {5'd8,  32'h0000ffff, 5'd8,  32'hffffffff, 4'd2},  // R2
    {5'd9,  32'h00008000, 5'd9,  32'hffff8000, 4'd2},  // R2
    {5'd10, 32'h00001234, 5'd10, 32'h00001234, 4'd2},  // R2
    {5'd1,  32'h0000ff00, 5'd1,  32'hffffff00, 4'd2},  // R2
    {5'd7,  32'hffffffff, 5'd7,  32'h0000ffff, 4'd3},  // R3
    {5'd16, 32'hdeadbeef, 5'd16, 32'h0000beef, 4'd3},  // R3
    {5'd30, 32'h00000000, 5'd31, 32'd32,       4'd7},  // R7
    {5'd30, 32'hffffffff, 5'd31, 32'd32,       4'd7},  // R7
    {5'd30, 32'h00000001, 5'd31, 32'd31,       4'd7},  // R7
    {5'd30, 32'h80000000, 5'd31, 32'd1,        4'd7},  // R7
    {5'd30, 32'h00010000, 5'd31, 32'd15,       4'd7},  // R7
    {5'd30, 32'hfffe0000, 5'd31, 32'd15,       4'd7},  // R7
    {5'd28, 32'h12345678, 5'd28, 32'h00000000, 4'd9},  // R9
    {5'd29, 32'h0000ffff, 5'd29, 32'h00000000, 4'd9}   // R9
  };

  task automatic doWrite(input logic [4:0] idx, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkRead(input logic [4:0] idx, input logic [31:0] exp, input string req);
    rdIdx = idx;
    #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s idx=%0d actual=%08h expected=%08h", req, idx, rdData, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    for (int i = 0; i < 31; i++) checkRead(5'(i), 32'h0, "R10");
    checkRead(5'd31, 32'd32, "R10");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      doWrite(VECS[v][77:73], VECS[v][72:41]);
      checkRead(VECS[v][40:36], VECS[v][35:4], $sformatf("R%0d", VECS[v][3:0]));
    end

    // R4 and R5: direct fill, then one push
    doWrite(5'd12, 32'h00010002);
    doWrite(5'd13, 32'h00030004);
    doWrite(5'd14, 32'h00050006);
    checkRead(5'd12, 32'h00010002, "R4");
    checkRead(5'd14, 32'h00050006, "R4");
    doWrite(5'd15, 32'h00070008);
    checkRead(5'd12, 32'h00030004, "R5");
    checkRead(5'd13, 32'h00050006, "R5");
    checkRead(5'd14, 32'h00070008, "R5");

    // R5: three pushes flush older content
    doWrite(5'd15, 32'h11111111);
    doWrite(5'd15, 32'h22222222);
    doWrite(5'd15, 32'h33333333);
    checkRead(5'd12, 32'h11111111, "R5");
    checkRead(5'd13, 32'h22222222, "R5");
    checkRead(5'd14, 32'h33333333, "R5");

    // R6: alias read of newest entry
    doWrite(5'd14, 32'haabbccdd);
    checkRead(5'd15, 32'haabbccdd, "R6");
    checkRead(5'd13, 32'h22222222, "R6");

    // R8: write to count index is ignored
    doWrite(5'd30, 32'h00010000);
    doWrite(5'd31, 32'hffffffff);
    checkRead(5'd31, 32'd15, "R8");
    checkRead(5'd30, 32'h00010000, "R8");
    checkRead(5'd15, 32'haabbccdd, "R8");

    // R1: an unnamed index keeps all bits
    doWrite(5'd20, 32'h80008000);
    checkRead(5'd20, 32'h80008000, "R1");

    // R10: reset clears again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checkRead(5'd25, 32'h0, "R10");
    checkRead(5'd14, 32'h0, "R10");
    checkRead(5'd31, 32'd32, "R10");
    rst_n = 1'b1;
    finish();
  end
endmodule